// File: doc/BRIEF.md
# Two-Register Accumulator Processor Core

This block is a single-cycle 16-bit processor core. It has an address register A, a data register D, and a memory operand M, which is the data-memory word that A points to. Each clock cycle it takes one instruction word from an external instruction memory, indexed by the program counter. It exchanges one word with an external data memory through a combinational read port and a write strobe.

There are two instruction kinds. An address instruction loads a constant into A. A compute instruction feeds D and a second operand to a small ALU. The second operand is either A or M. The result can go to any subset of A, D and M.

The memory timing is exact. During an instruction, the memory address is the value A held when that instruction began. This address is used both for the M operand and for the M write. A new value written to A only takes effect as an address from the next instruction onward.

Top module: `acc_core`

## Requirements
- R1: Bit 15 selects the instruction kind. When bit 15 is 0, the instruction is an address instruction: bits 14:0, zero-extended, become the new A at the clock edge, D keeps its value, and `write_m` stays low.
- R2: When bit 15 is 1, the instruction is a compute instruction. Bit 12 selects the second ALU operand X (0 = A, 1 = `in_m`). Bits 11:8 hold the opcode. Bits 5:3 are destination flags for A (bit 5), D (bit 4) and M (bit 3). Bits 14:13, 7:6 and 2:0 have no effect.
- R3: The opcodes produce: 0→0, 1→1, 2→-1, 3→D, 4→X, 5→D+X, 6→D-X, 7→X-D, 8→D&X, 9→D|X, 10→~D, 11→~X, 12→-D, 13→-X, 14→D+1, 15→X+1. All arithmetic is modulo 2^16.
- R4: `out_m` always carries the ALU result. `write_m` goes high combinationally, in the same cycle, exactly when a compute instruction has its M flag set and reset is low.
- R5: `address_m` equals the low 15 bits of A for the whole instruction. A memory write goes to that address even when the same instruction also writes A.
- R6: The M operand is read at the address A held at the start of the instruction. A value written to A becomes the memory address only from the next instruction.
- R7: A and D take the ALU result at the clock edge that ends a compute instruction, and only if their flag is set. A register whose flag is clear keeps its value.
- R8: `pc` increments by one on every clock edge. A synchronous reset sets `pc` to 0. While reset is high, A, D and memory are not written.
- R9: Take mem[1]=0 and mem[2]=7, and run: load 2 into A, D=1, A=D, AMD=M+D. The last instruction reads mem[1]. The sequence leaves A=1, D=1, mem[1]=1 and mem[2] unchanged.
- R10: Run: load 1 into A, MD=0, D=A, AMD=D+A. The sequence leaves A=2, D=2 and mem[1]=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset |
| instr | input | 16 | Instruction word at `pc` |
| in_m | input | 16 | Data memory word at `address_m` |
| out_m | output | 16 | ALU result, data to write to memory |
| write_m | output | 1 | Memory write strobe for this cycle |
| address_m | output | 15 | Data memory address (current A) |
| pc | output | 15 | Program counter, instruction address |

## Verification
On every cycle, the assertions check the following. An address instruction loads its constant into A and never strobes memory. `write_m` follows the M flag. The address port tracks A. A and D load the previous cycle's ALU result, or hold when their flag is clear. The program counter steps by one. Only the bench's scenarios can show the ALU opcode values, the use of the old address for both the operand and the write when A is overwritten, and the final register and memory contents of the two instruction sequences.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
  localparam int KIND_BIT = 15;
  localparam int SEL_BIT  = 12;
  localparam int OP_LSB   = 8;
  localparam int OP_W     = 4;
  localparam int DST_A    = 5;
  localparam int DST_D    = 4;
  localparam int DST_M    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ZERO = 4'd0,  OP_ONE  = 4'd1,  OP_NEG1 = 4'd2,  OP_D    = 4'd3,
    OP_X    = 4'd4,  OP_ADD  = 4'd5,  OP_DSUB = 4'd6,  OP_XSUB = 4'd7,
    OP_AND  = 4'd8,  OP_OR   = 4'd9,  OP_NOTD = 4'd10, OP_NOTX = 4'd11,
    OP_NEGD = 4'd12, OP_NEGX = 4'd13, OP_INCD = 4'd14, OP_INCX = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic    is_addr;
    logic    sel_m;
    alu_op_e op;
    logic    dst_a;
    logic    dst_d;
    logic    dst_m;
  } ctrl_t;
endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] instr,
  output ctrl_t        ctrl,
  output logic [W-1:0] konst
);
  always_comb begin
    ctrl.is_addr = ~instr[KIND_BIT];
    ctrl.sel_m   = instr[SEL_BIT];
    ctrl.op      = alu_op_e'(instr[OP_LSB +: OP_W]);
    ctrl.dst_a   = instr[KIND_BIT] & instr[DST_A];
    ctrl.dst_d   = instr[KIND_BIT] & instr[DST_D];
    ctrl.dst_m   = instr[KIND_BIT] & instr[DST_M];
    konst        = {1'b0, instr[W-2:0]};
  end
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] x,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] alu_fn(input logic [W-1:0] dv,
                                          input logic [W-1:0] xv,
                                          input alu_op_e      o);
    logic [W-1:0] r;
    unique case (o)
      OP_ZERO: r = '0;
      OP_ONE:  r = ONE;
      OP_NEG1: r = '1;
      OP_D:    r = dv;
      OP_X:    r = xv;
      OP_ADD:  r = dv + xv;
      OP_DSUB: r = dv - xv;
      OP_XSUB: r = xv - dv;
      OP_AND:  r = dv & xv;
      OP_OR:   r = dv | xv;
      OP_NOTD: r = ~dv;
      OP_NOTX: r = ~xv;
      OP_NEGD: r = '0 - dv;
      OP_NEGX: r = '0 - xv;
      OP_INCD: r = dv + ONE;
      OP_INCX: r = xv + ONE;
      default: r = '0;
    endcase
    return r;
  endfunction

  assign y = alu_fn(d, x, op);
endmodule

// File: rtl/acc_core_regs.sv
module acc_core_regs #(
  parameter int W    = 16,
  parameter int PC_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            a_we,
  input  logic [W-1:0]    a_nxt,
  input  logic            d_we,
  input  logic [W-1:0]    d_nxt,
  output logic [W-1:0]    a_q,
  output logic [W-1:0]    d_q,
  output logic [PC_W-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (a_we) a_q <= a_nxt;
    if (d_we) d_q <= d_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int W    = 16,
  parameter int PC_W = 15,
  localparam int AW  = W - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    instr,
  input  logic [W-1:0]    in_m,
  output logic [W-1:0]    out_m,
  output logic            write_m,
  output logic [AW-1:0]   address_m,
  output logic [PC_W-1:0] pc
);
  ctrl_t        ctrl;
  logic [W-1:0] konst;
  logic [W-1:0] a_q, d_q;
  logic [W-1:0] alu_x, alu_y;
  logic [W-1:0] a_nxt;
  logic         a_we, d_we;

  acc_core_decode #(.W(W)) u_dec (
    .instr (instr),
    .ctrl  (ctrl),
    .konst (konst)
  );

  assign alu_x = ctrl.sel_m ? in_m : a_q;

  acc_core_alu #(.W(W)) u_alu (
    .d  (d_q),
    .x  (alu_x),
    .op (ctrl.op),
    .y  (alu_y)
  );

  assign a_we  = ~rst & (ctrl.is_addr | ctrl.dst_a);
  assign d_we  = ~rst & ctrl.dst_d;
  assign a_nxt = ctrl.is_addr ? konst : alu_y;

  acc_core_regs #(.W(W), .PC_W(PC_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .a_we  (a_we),
    .a_nxt (a_nxt),
    .d_we  (d_we),
    .d_nxt (alu_y),
    .a_q   (a_q),
    .d_q   (d_q),
    .pc_q  (pc)
  );

  assign out_m     = alu_y;
  assign write_m   = ~rst & ctrl.dst_m;
  assign address_m = a_q[AW-1:0];
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int W    = 16,
  parameter int PC_W = 15
) (
  input logic            clk,
  input logic            rst,
  input logic [W-1:0]    instr,
  input logic [W-1:0]    out_m,
  input logic            write_m,
  input logic [W-2:0]    address_m,
  input logic [PC_W-1:0] pc,
  input logic [W-1:0]    a_q,
  input logic [W-1:0]    d_q
);
  logic is_c;
  assign is_c = instr[KIND_BIT];

  a_r1_addr_load: assert property (@(posedge clk) disable iff (rst)
    !is_c |=> a_q == $past({1'b0, instr[W-2:0]}));

  a_r1_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !is_c |-> !write_m);

  a_r4_strobe_flag: assert property (@(posedge clk) disable iff (rst)
    write_m == (is_c && instr[DST_M]));

  a_r5_addr_is_a: assert property (@(posedge clk) disable iff (rst)
    address_m == a_q[W-2:0]);

  a_r7_a_load: assert property (@(posedge clk) disable iff (rst)
    (is_c && instr[DST_A]) |=> a_q == $past(out_m));

  a_r7_a_hold: assert property (@(posedge clk) disable iff (rst)
    (is_c && !instr[DST_A]) |=> a_q == $past(a_q));

  a_r7_d_load: assert property (@(posedge clk) disable iff (rst)
    (is_c && instr[DST_D]) |=> d_q == $past(out_m));

  a_r7_d_hold: assert property (@(posedge clk) disable iff (rst)
    !(is_c && instr[DST_D]) |=> d_q == $past(d_q));

  a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc == PC_W'($past(pc) + 1'b1));
endmodule

bind acc_core acc_core_chk #(.W(W), .PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr     (instr),
  .out_m     (out_m),
  .write_m   (write_m),
  .address_m (address_m),
  .pc        (pc),
  .a_q       (a_q),
  .d_q       (d_q)
);

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [15:0] in_m;
  logic [15:0] out_m;
  logic        write_m;
  logic [14:0] address_m;
  logic [14:0] pc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] mem [0:255];

  always #5 clk = ~clk;

  acc_core dut_i (
    .clk(clk), .rst(rst), .instr(instr), .in_m(in_m),
    .out_m(out_m), .write_m(write_m), .address_m(address_m), .pc(pc)
  );

  assign in_m = mem[address_m[7:0]];
  always @(posedge clk) if (write_m) mem[address_m[7:0]] <= out_m;

  typedef struct packed { logic [15:0] ins; logic [15:0] exp; } vec_t;
  // D=6, A=3, mem[3]=10, no destinations (R3)
  localparam vec_t VECS [24] = '{
    '{16'hE000, 16'h0000}, '{16'hE100, 16'h0001}, '{16'hE200, 16'hFFFF},
    '{16'hE300, 16'h0006}, '{16'hE400, 16'h0003}, '{16'hE500, 16'h0009},
    '{16'hE600, 16'h0003}, '{16'hE700, 16'hFFFD}, '{16'hE800, 16'h0002},
    '{16'hE900, 16'h0007}, '{16'hEA00, 16'hFFF9}, '{16'hEB00, 16'hFFFC},
    '{16'hEC00, 16'hFFFA}, '{16'hED00, 16'hFFFD}, '{16'hEE00, 16'h0007},
    '{16'hEF00, 16'h0004}, '{16'hF400, 16'h000A}, '{16'hF500, 16'h0010},
    '{16'hF600, 16'hFFFC}, '{16'hF700, 16'h0004}, '{16'hF800, 16'h0002},
    '{16'hF900, 16'h000E}, '{16'hFB00, 16'hFFF5}, '{16'hFF00, 16'h000B}
  };

  function automatic logic [15:0] mk_c(input logic sel, input logic [3:0] op,
                                       input logic [2:0] dst);
    return {3'b111, sel, op, 2'b00, dst, 3'b000};
  endfunction

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] ins);
    @(negedge clk);
    instr = ins;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [14:0] pc0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[3]  = 16'h000A;
    mem[10] = 16'h1234;

    // R8: reset, writes suppressed
    step(mk_c(0, 4'd0, 3'b001));
    check("R8 write_m low in reset", {15'd0, write_m}, 16'h0000);
    repeat (2) @(posedge clk);
    #1 check("R8 pc cleared", {1'b0, pc}, 16'h0000);
    step(16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R8 pc after release", {1'b0, pc}, 16'h0001);
    @(negedge clk);
    check("R8 pc increments", {1'b0, pc}, 16'h0002);

    // R3 table walk, with R2 unused bits set in the table words
    step(16'h0006);
    step(mk_c(0, 4'd4, 3'b010));
    step(16'h0003);
    foreach (VECS[i]) begin
      step(VECS[i].ins);
      check($sformatf("R3 op vec %0d", i), out_m, VECS[i].exp);
      check("R4 no strobe without M flag", {15'd0, write_m}, 16'h0000);
    end

    // R1: address instruction, 15-bit constant, zero-extended
    step(16'h7FFF);
    check("R1 no strobe on address instr", {15'd0, write_m}, 16'h0000);
    step(mk_c(0, 4'd4, 3'b000));
    check("R1 constant in A", out_m, 16'h7FFF);
    check("R5 address from A", {1'b0, address_m}, 16'h7FFF);
    step(mk_c(0, 4'd3, 3'b000));
    check("R1 D untouched by address instr", out_m, 16'h0006);

    // R6: A=M uses the old address; the new A addresses the next instr
    step(16'h0003);
    step(mk_c(1, 4'd4, 3'b100));
    check("R6 operand at old address", out_m, 16'h000A);
    step(mk_c(1, 4'd4, 3'b000));
    check("R6 new address next instr", {1'b0, address_m}, 16'h000A);
    check("R6 operand at new address", out_m, 16'h1234);

    // R7: D keeps value when only A is written
    step(16'h0009);
    step(mk_c(0, 4'd4, 3'b010));
    step(mk_c(0, 4'd0, 3'b100));
    step(mk_c(0, 4'd3, 3'b000));
    check("R7 D held", out_m, 16'h0009);
    check("R7 A loaded", {1'b0, address_m}, 16'h0000);

    // R9 sequence
    mem[1] = 16'h0000; mem[2] = 16'h0007;
    step(16'h0002);
    step(mk_c(0, 4'd1, 3'b010));
    step(mk_c(0, 4'd3, 3'b100));
    step(mk_c(1, 4'd5, 3'b111));
    check("R9 address during AMD", {1'b0, address_m}, 16'h0001);
    check("R9 result", out_m, 16'h0001);
    check("R4 strobe with M flag", {15'd0, write_m}, 16'h0001);
    step(mk_c(0, 4'd3, 3'b000));
    check("R9 D", out_m, 16'h0001);
    check("R9 A", {1'b0, address_m}, 16'h0001);
    check("R9 mem[1]", mem[1], 16'h0001);
    check("R9 mem[2] unchanged", mem[2], 16'h0007);

    // R10 sequence
    step(16'h0001);
    step(mk_c(0, 4'd0, 3'b011));
    step(mk_c(0, 4'd4, 3'b010));
    step(mk_c(0, 4'd5, 3'b111));
    check("R5 write address is old A", {1'b0, address_m}, 16'h0001);
    check("R10 result", out_m, 16'h0002);
    step(mk_c(0, 4'd3, 3'b000));
    check("R10 D", out_m, 16'h0002);
    check("R10 A", {1'b0, address_m}, 16'h0002);
    check("R10 mem[1]", mem[1], 16'h0002);
    check("R10 mem[2] untouched", mem[2], 16'h0007);

    // R8: pc keeps counting
    pc0 = pc;
    @(negedge clk);
    check("R8 pc step", {1'b0, pc}, {1'b0, pc0 + 15'd1});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule